// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides an 8-bit unsigned dividend by an 8-bit divisor and returns an 8-bit quotient and an 8-bit remainder. It uses the non-restoring method. A 9-bit signed partial remainder is either reduced or increased by the divisor on each iteration. The choice is made by a one-bit register that holds the sign of the previous partial remainder. Each iteration uses one shared add/subtract unit, built as a carry-select adder.

Operands enter through a valid/ready handshake. A request is taken on a rising edge where `in_valid` and `in_ready` are both high, and that edge is the setup cycle that loads the registers. Eight iteration edges follow. `in_ready` stays low for the whole computation, so a request offered meanwhile is simply not taken; the source must hold it until `in_ready` returns. The result side has no back-pressure. `out_valid` is a single-cycle pulse, and the quotient and remainder stay on the outputs until the next request is taken. A new request may be taken in the same cycle that `out_valid` is high.

If the last partial remainder is negative, the divisor is added back combinationally on the remainder output path. This costs no extra cycle.

Top module: `nrdiv_unit`

## Requirements
- R1: After synchronous reset `in_ready` is 1, `out_valid` is 0, and `out_quotient` and `out_remainder` are 0.
- R2: For a nonzero divisor, `out_quotient` equals floor(dividend / divisor) in the cycle where `out_valid` is 1.
- R3: For a nonzero divisor, `out_remainder` equals dividend mod divisor and is less than the divisor in the cycle where `out_valid` is 1.
- R4: `out_valid` is 1 in the cycle after the ninth rising edge, counting the accepting edge as the first (one setup edge plus eight iteration edges). It is 0 in every cycle before that.
- R5: `in_ready` is 0 from the edge that takes a request until `out_valid` rises. Requests offered while it is 0 are not taken and do not change the result.
- R6: `out_valid` is high for exactly one cycle per request taken.
- R7: `out_quotient` and `out_remainder` hold their values while no new request is taken.
- R8: A zero divisor gives quotient 8'hFF and remainder equal to the dividend, with the same timing as R4.
- R9: A request offered in the cycle where `out_valid` is 1 is taken at once, and its result follows after the latency of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand request |
| in_ready | output | 1 | High when a request can be taken |
| in_dividend | input | 8 | Unsigned dividend |
| in_divisor | input | 8 | Unsigned divisor |
| out_valid | output | 1 | One-cycle result pulse |
| out_quotient | output | 8 | Quotient |
| out_remainder | output | 8 | Remainder, corrected if negative |

## Verification
Most internal faults show up at the ports when the result pulse arrives, nine edges after the request.

- A wrong sign register or a wrong add/subtract choice corrupts both the quotient bits and the remainder.
- A wrong shift of the low dividend bits or a wrong quotient bit shows mainly in the quotient, and often in the remainder too.
- A control counter that is off by one moves the result pulse and the return of `in_ready` by a cycle, which shows at once.
- A request that leaks in while the block is busy replaces the operands, and the returned result no longer matches the first request.

Random operands mixed with directed extremes (zero divisor, divisor of one, dividend smaller than the divisor, all-ones values) exercise both the add path and the subtract path, and the final add-back correction.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/nrdiv_addsub.sv
module nrdiv_addsub #(
  parameter int W  = 9,
  parameter int LO = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);
  logic [W-1:0] bx;
  assign bx = b ^ {W{sub}};

  generate
    if (LO > 0 && LO < W) begin : g_csel
      localparam int HI = W - LO;
      logic [LO:0]   lo_sum;
      logic [HI-1:0] hi_c0;
      logic [HI-1:0] hi_c1;
      assign lo_sum = {1'b0, a[LO-1:0]} + {1'b0, bx[LO-1:0]} + {{LO{1'b0}}, sub};
      assign hi_c0  = a[W-1:LO] + bx[W-1:LO];
      assign hi_c1  = a[W-1:LO] + bx[W-1:LO] + {{(HI-1){1'b0}}, 1'b1};
      assign y      = {(lo_sum[LO] ? hi_c1 : hi_c0), lo_sum[LO-1:0]};
    end else begin : g_ripple
      assign y = a + bx + {{(W-1){1'b0}}, sub};
    end
  endgenerate
endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int STEPS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic out_valid
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int MW = $clog2(STEPS + 1) + 1;

  run_state_e    state;
  logic [CW-1:0] cnt;
  logic          last;

  assign in_ready = (state == ST_IDLE);
  assign load     = in_valid && in_ready;
  assign step     = (state == ST_RUN);
  assign last     = (cnt == CW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (load) begin
        state <= ST_RUN;
        cnt   <= '0;
      end else if (step) begin
        cnt <= cnt + 1'b1;
        if (last) begin
          state     <= ST_IDLE;
          out_valid <= 1'b1;
        end
      end
    end
  end

  // Checker-only latency monitor: edges since the last taken request.
  logic [MW-1:0] mon;
  always_ff @(posedge clk) begin
    if (rst)                      mon <= '1;
    else if (load)                mon <= '0;
    else if (mon != MW'(STEPS) && mon != '1) mon <= mon + 1'b1;
  end

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    load |=> !in_ready); // R5
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (mon == MW'(STEPS))); // R4
  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready); // R9
endmodule

// File: rtl/nrdiv_datapath.sv
module nrdiv_datapath #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] quot,
  output logic [DW-1:0] rem,
  output logic [DW-1:0] dsr_held
);
  localparam int PW = DW + 1;

  logic [PW-1:0] part;
  logic [DW-1:0] low;
  logic [DW-1:0] dsr;
  logic [DW-1:0] quo;
  logic          neg;
  logic [PW-1:0] win;
  logic [PW-1:0] sum;

  assign win = {part[DW-1:0], low[DW-1]};

  nrdiv_addsub #(.W(PW), .LO(PW / 2)) u_addsub (
    .a  (win),
    .b  ({1'b0, dsr}),
    .sub(~neg),
    .y  (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      part <= '0;
      low  <= '0;
      dsr  <= '0;
      quo  <= '0;
      neg  <= 1'b0;
    end else if (load) begin
      part <= '0;
      low  <= dividend;
      dsr  <= divisor;
      quo  <= '0;
      neg  <= 1'b0;
    end else if (step) begin
      part <= sum;
      neg  <= sum[DW];
      low  <= {low[DW-2:0], 1'b0};
      quo  <= {quo[DW-2:0], ~sum[DW]};
    end
  end

  assign quot     = quo;
  assign rem      = neg ? (part[DW-1:0] + dsr) : part[DW-1:0];
  assign dsr_held = dsr;

  logic signed [PW:0] ps;
  logic signed [PW:0] ds;
  assign ps = $signed({part[DW], part});
  assign ds = $signed({2'b00, dsr});

  AST_PART_RANGE: assert property (@(posedge clk) disable iff (rst)
    (ds != 0) |-> ((ps < ds) && (ps >= -ds))); // R3
endmodule

// File: rtl/nrdiv_unit.sv
module nrdiv_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_dividend,
  input  logic [DW-1:0] in_divisor,
  output logic          out_valid,
  output logic [DW-1:0] out_quotient,
  output logic [DW-1:0] out_remainder
);
  logic          load;
  logic          step;
  logic [DW-1:0] dsr_held;

  nrdiv_ctrl #(.STEPS(DW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .load     (load),
    .step     (step),
    .out_valid(out_valid)
  );

  nrdiv_datapath #(.DW(DW)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (step),
    .dividend(in_dividend),
    .divisor (in_divisor),
    .quot    (out_quotient),
    .rem     (out_remainder),
    .dsr_held(dsr_held)
  );

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && dsr_held != 0) |-> (out_remainder < dsr_held)); // R3
  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && dsr_held == 0) |-> (out_quotient == '1)); // R8
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> ($stable(out_quotient) && $stable(out_remainder))); // R7
endmodule

// File: tb/test_nrdiv_unit.sv
module test_nrdiv_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_dividend = '0;
  logic [7:0] in_divisor = '0;
  logic       out_valid;
  logic [7:0] out_quotient;
  logic [7:0] out_remainder;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 4 ns period

  nrdiv_unit i_nrdiv_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor),
    .out_valid(out_valid), .out_quotient(out_quotient), .out_remainder(out_remainder)
  );

  function automatic logic [7:0] exp_q(input logic [7:0] a, input logic [7:0] b);
    return (b == 0) ? 8'hFF : a / b;
  endfunction

  function automatic logic [7:0] exp_r(input logic [7:0] a, input logic [7:0] b);
    return (b == 0) ? a : a % b;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // At a negedge: offer a request; return at the negedge after the taking edge.
  task automatic launch(input logic [7:0] a, input logic [7:0] b);
    in_valid = 1'b1; in_dividend = a; in_divisor = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Wait for the result and check timing and values; returns at the result negedge.
  task automatic collect(input logic [7:0] a, input logic [7:0] b, input bit junk);
    string tq;
    string tr;
    tq = (b == 0) ? "R8 quotient" : "R2 quotient";
    tr = (b == 0) ? "R8 remainder" : "R3 remainder";
    for (int i = 1; i <= 8; i++) begin
      if (junk) begin
        in_valid = 1'b1;
        in_dividend = 8'($urandom);
        in_divisor = 8'($urandom);
      end
      @(negedge clk);
      if (i == 8) in_valid = 1'b0;
      if (i < 8) begin
        check("R4 early out_valid", {31'b0, out_valid}, 32'd0);
        check("R5 in_ready busy", {31'b0, in_ready}, 32'd0);
      end
    end
    check("R4 out_valid", {31'b0, out_valid}, 32'd1);
    check(tq, {24'b0, out_quotient}, {24'b0, exp_q(a, b)});
    check(tr, {24'b0, out_remainder}, {24'b0, exp_r(a, b)});
    if (b != 0) check("R3 rem below divisor", {31'b0, out_remainder < b}, 32'd1);
  endtask

  // After a result: idle for a few cycles and check pulse width and holding.
  task automatic idle_hold(input logic [7:0] a, input logic [7:0] b);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R6 pulse width", {31'b0, out_valid}, 32'd0);
      check("R7 hold quotient", {24'b0, out_quotient}, {24'b0, exp_q(a, b)});
      check("R7 hold remainder", {24'b0, out_remainder}, {24'b0, exp_r(a, b)});
    end
  endtask

  task automatic run_one(input logic [7:0] a, input logic [7:0] b, input bit junk);
    launch(a, b);
    collect(a, b, junk);
    idle_hold(a, b);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 in_ready", {31'b0, in_ready}, 32'd1);
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    check("R1 quotient", {24'b0, out_quotient}, 32'd0);
    check("R1 remainder", {24'b0, out_remainder}, 32'd0);

    // Directed corners (R2, R3, R8)
    run_one(8'd100, 8'd7, 1'b0);
    run_one(8'd5, 8'd5, 1'b0);
    run_one(8'd3, 8'd200, 1'b0);
    run_one(8'hFF, 8'd1, 1'b0);
    run_one(8'hFF, 8'hFF, 1'b0);
    run_one(8'hFE, 8'hFF, 1'b0);
    run_one(8'd0, 8'd9, 1'b0);
    run_one(8'd173, 8'd0, 1'b0);  // R8
    run_one(8'd0, 8'd0, 1'b0);    // R8
    run_one(8'd200, 8'd128, 1'b1); // R5 with requests offered while busy

    // R9 back-to-back: next request offered in the result cycle
    launch(8'd77, 8'd6);
    collect(8'd77, 8'd6, 1'b0);
    launch(8'd250, 8'd13);
    collect(8'd250, 8'd13, 1'b0);
    launch(8'd9, 8'd0);
    collect(8'd9, 8'd0, 1'b0);
    idle_hold(8'd9, 8'd0);

    // Random operands
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      logic [7:0] b;
      a = 8'($urandom);
      b = 8'($urandom);
      if (k % 37 == 0) b = 8'd0;
      if (k % 3 == 0) begin
        launch(a, b);
        collect(a, b, (k % 2) == 1);
      end else begin
        run_one(a, b, (k % 5) == 0);
      end
    end
    @(negedge clk);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule